// File: doc/BRIEF.md
# Splittable Pair Code Stream Decoder

This block takes a serial bitstream, one bit per handshake, and cuts it into codewords that each carry an ordered pair of integers. A codeword starts with a fixed-width head field holding the first member of the pair. A variable-length tail follows, holding the second member. The tail ends where a run of ones of an allowed length is followed by a zero, or by the end of the stream. The set of allowed run lengths is a parameter. Parsing is a single left-to-right pass with no backtracking.

For each codeword the block presents one output record. The record holds the head value, the raw tail bits and the tail length. An error flag marks tails that overflow the collection register and streams that end inside a codeword. Turning the tail pattern into an integer index is left to a downstream stage. The decoder looks at the bit after a run before it decides whether the run has ended. When that bit ends the codeword, it is left unconsumed on the input and becomes the first bit of the next head.

Top module: `spc_pair_decoder`

## Requirements
- R1: The head field is FIRST_W (default 2) bits wide. The first bit received is its most significant bit, and its value appears on `out_first` of the record.
- R2: `out_bits` holds the tail bits in its lowest `out_len` positions, with the earliest received bit most significant. Every bit above `out_len` reads zero.
- R3: When a run of ones whose length is in the allowed set (default 2 or 3) is followed by a 0 bit, the tail ends with that run and `out_err` is 0. The 0 is not accepted with the codeword; it becomes the first head bit of the next codeword.
- R4: When the stream-end bit (`in_last`) completes a run of ones of an allowed length, that bit is part of the tail and the record has `out_err` 0.
- R5: A run of ones whose length is not in the set, whether shorter or longer than the longest allowed run, does not end the tail; its bits and the following 0 stay in the tail.
- R6: A tail that consists of nothing but an allowed run, such as `11` with the default set, forms a complete codeword of that length.
- R7: A tail may hold up to MAX_LEN (default 32) bits without error. If MAX_LEN bits are already held and the next bit is not an ending 0, the record is emitted with `out_err` 1 and `out_len` equal to MAX_LEN. That bit is left unconsumed and starts the next head.
- R8: When `in_last` arrives on a bit that leaves a codeword unfinished, a record is emitted with `out_err` 1 that contains every bit received so far. An unfinished head gives `out_len` 0, with the partial head bits shifted in at the least significant end of `out_first`.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` stays low and every record field holds its value.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input bit is offered |
| in_bit | input | 1 | The offered bit |
| in_last | input | 1 | The offered bit is the final bit of the stream |
| in_ready | output | 1 | The offered bit is accepted at this edge |
| out_valid | output | 1 | A pair record is held |
| out_ready | input | 1 | The downstream stage takes the record |
| out_first | output | FIRST_W | First member of the pair (head value) |
| out_bits | output | MAX_LEN | Raw tail bits, right-aligned |
| out_len | output | LEN_W | Number of valid tail bits |
| out_err | output | 1 | Overflow or truncated codeword |

## Verification
The hardest state to reach is the tail register at exactly full length while the next bit is not an ending zero. Reaching it takes a 32-bit tail that contains no allowed run at all. The stimulus uses an alternating one-zero pattern, whose single-one runs never end a tail, and follows it with one more zero. It then checks that this zero was left on the input by decoding the next codeword's head after it. A second stream stops one bit short of overflow and ends on an allowed run, which covers the full-length success case.

// File: rtl/spc_pkg.sv
package spc_pkg;

  localparam int unsigned DMASK_W = 16;

  typedef enum logic {ST_HEAD, ST_BODY} spc_state_e;

  // True when a run of ones of length run is an allowed delimiter.
  function automatic logic run_is_delim(input logic [DMASK_W-1:0] mask,
                                        input logic [7:0] run);
    return (run != 8'd0) && (run < 8'(DMASK_W)) && mask[run[3:0]];
  endfunction

  function automatic int unsigned delim_longest(input logic [DMASK_W-1:0] mask);
    int unsigned r;
    r = 0;
    for (int i = 1; i < DMASK_W; i++) if (mask[i]) r = i;
    return r;
  endfunction

  function automatic int unsigned delim_shortest(input logic [DMASK_W-1:0] mask);
    int unsigned r;
    r = 0;
    for (int i = DMASK_W - 1; i >= 1; i--) if (mask[i]) r = i;
    return r;
  endfunction

endpackage

// File: rtl/spc_run_track.sv
module spc_run_track #(
  parameter int unsigned RUN_SAT = 4,
  parameter int unsigned RUN_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             bit_in,
  output logic [RUN_W-1:0] run_q,
  output logic [RUN_W-1:0] run_nx
);

  // Length of the current run of ones, saturating one above the longest delimiter.
  always_comb begin
    if (!bit_in)                       run_nx = '0;
    else if (run_q == RUN_W'(RUN_SAT)) run_nx = run_q;
    else                               run_nx = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (clr)  run_q <= '0;
    else if (push) run_q <= run_nx;
  end

  a_r5_run_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(RUN_SAT));

endmodule

// File: rtl/spc_collect.sv
module spc_collect #(
  parameter int unsigned MAX_LEN = 32,
  parameter int unsigned LEN_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic               bit_in,
  output logic [MAX_LEN-1:0] bits_q,
  output logic [LEN_W-1:0]   len_q,
  output logic [MAX_LEN-1:0] bits_nx,
  output logic [LEN_W-1:0]   len_nx,
  output logic               full
);

  assign bits_nx = {bits_q[MAX_LEN-2:0], bit_in};
  assign len_nx  = len_q + LEN_W'(1);
  assign full    = (len_q == LEN_W'(MAX_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      len_q  <= '0;
    end else if (clr) begin
      bits_q <= '0;
      len_q  <= '0;
    end else if (push) begin
      bits_q <= bits_nx;
      len_q  <= len_nx;
    end
  end

  a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(MAX_LEN));

  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

endmodule

// File: rtl/spc_head.sv
module spc_head #(
  parameter int unsigned FIRST_W = 2,
  parameter int unsigned CNT_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic               bit_in,
  output logic [FIRST_W-1:0] val_q,
  output logic [FIRST_W-1:0] val_nx,
  output logic               done
);

  logic [CNT_W-1:0] cnt_q;

  generate
    if (FIRST_W == 1) begin : g_one
      assign val_nx = bit_in;
    end else begin : g_many
      assign val_nx = {val_q[FIRST_W-2:0], bit_in};
    end
  endgenerate

  // The bit being pushed completes the head field.
  assign done = (cnt_q == CNT_W'(FIRST_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (push) begin
      val_q <= val_nx;
      cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
    end
  end

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FIRST_W - 1));

endmodule

// File: rtl/spc_pair_decoder.sv
module spc_pair_decoder
  import spc_pkg::*;
#(
  parameter int unsigned          FIRST_W    = 2,
  parameter int unsigned          MAX_LEN    = 32,
  parameter logic [DMASK_W-1:0]   DELIM_MASK = 16'h000C,
  parameter int unsigned          LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_bit,
  input  logic               in_last,
  output logic               in_ready,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FIRST_W-1:0] out_first,
  output logic [MAX_LEN-1:0] out_bits,
  output logic [LEN_W-1:0]   out_len,
  output logic               out_err
);

  localparam int unsigned MAX_DELIM = delim_longest(DELIM_MASK);
  localparam int unsigned MIN_DELIM = delim_shortest(DELIM_MASK);
  localparam int unsigned RUN_SAT   = MAX_DELIM + 1;
  localparam int unsigned RUN_W     = $clog2(RUN_SAT + 1);
  localparam int unsigned CNT_W     = (FIRST_W > 1) ? $clog2(FIRST_W) : 1;

  spc_state_e state_q, state_d;

  logic [FIRST_W-1:0] head_q, head_nx;
  logic               head_done;
  logic [MAX_LEN-1:0] col_bits, col_bits_nx;
  logic [LEN_W-1:0]   col_len, col_len_nx;
  logic               col_full;
  logic [RUN_W-1:0]   run_q, run_nx;

  // Named internal events
  logic in_body, ev_term, ev_ovf, hold_bit, take, acc;
  logic head_push, body_push, enter_body, emit;
  logic run_delim, run_delim_nx;

  assign in_body      = (state_q == ST_BODY);
  assign run_delim    = run_is_delim(DELIM_MASK, 8'(run_q));
  assign run_delim_nx = run_is_delim(DELIM_MASK, 8'(run_nx));
  assign ev_term      = in_body && !in_bit && run_delim;
  assign ev_ovf       = in_body && !ev_term && col_full;
  assign hold_bit     = ev_term || ev_ovf;
  assign take         = in_valid && !out_valid;
  assign acc          = take && !hold_bit;
  assign head_push    = acc && !in_body;
  assign body_push    = acc && in_body;
  assign emit         = take && (hold_bit || in_last);
  assign enter_body   = head_push && head_done && !in_last;
  assign in_ready     = !out_valid && !hold_bit;

  spc_head #(.FIRST_W(FIRST_W), .CNT_W(CNT_W)) u_head (
    .clk(clk), .rst_n(rst_n), .clr(emit), .push(head_push), .bit_in(in_bit),
    .val_q(head_q), .val_nx(head_nx), .done(head_done)
  );

  spc_collect #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(emit || enter_body), .push(body_push),
    .bit_in(in_bit), .bits_q(col_bits), .len_q(col_len),
    .bits_nx(col_bits_nx), .len_nx(col_len_nx), .full(col_full)
  );

  spc_run_track #(.RUN_SAT(RUN_SAT), .RUN_W(RUN_W)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(emit || enter_body), .push(body_push),
    .bit_in(in_bit), .run_q(run_q), .run_nx(run_nx)
  );

  always_comb begin
    state_d = state_q;
    if (emit)            state_d = ST_HEAD;
    else if (enter_body) state_d = ST_BODY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HEAD;
    else        state_q <= state_d;
  end

  // Output record register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= '0;
      out_bits  <= '0;
      out_len   <= '0;
      out_err   <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      if (!in_body) begin
        out_first <= head_nx;
        out_bits  <= '0;
        out_len   <= '0;
        out_err   <= 1'b1;
      end else if (hold_bit) begin
        out_first <= head_q;
        out_bits  <= col_bits;
        out_len   <= col_len;
        out_err   <= ev_ovf;
      end else begin
        out_first <= head_q;
        out_bits  <= col_bits_nx;
        out_len   <= col_len_nx;
        out_err   <= !run_delim_nx;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bits) && $stable(out_len)
      && $stable(out_first) && $stable(out_err));

  a_r9_input_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r3_term_emits_ok: assert property (@(posedge clk) disable iff (!rst_n)
    take && ev_term |=> out_valid && !out_err);

  a_r7_ovf_emits_err: assert property (@(posedge clk) disable iff (!rst_n)
    take && ev_ovf |=> out_valid && out_err && out_len == LEN_W'(MAX_LEN));

  a_r4_ok_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_len >= LEN_W'(MIN_DELIM));

endmodule

// File: tb/spc_pair_decoder_tb.sv
module spc_pair_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_first;
  logic [31:0] out_bits;
  logic [5:0]  out_len;
  logic        out_err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spc_pair_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_first(out_first), .out_bits(out_bits),
    .out_len(out_len), .out_err(out_err)
  );

  // One codeword per stream, last bit carries in_last. Stream is MSB-first in VS.
  localparam logic [63:0] VS [NV] = '{64'b01011, 64'b100111, 64'b1111, 64'b001011,
    64'b0101111011, 64'b100100, 64'b1, 64'b111, 64'b0001111, 64'b010010111};
  localparam int          VN [NV] = '{5, 6, 4, 6, 10, 6, 1, 3, 7, 9};
  localparam logic [1:0]  VF [NV] = '{1, 2, 3, 0, 1, 2, 1, 3, 0, 1};
  localparam logic [31:0] VB [NV] = '{32'h3, 32'h7, 32'h3, 32'hB, 32'h7B, 32'h4,
    32'h0, 32'h1, 32'hF, 32'h17};
  localparam logic [5:0]  VL [NV] = '{3, 4, 2, 4, 8, 4, 0, 1, 5, 7};
  localparam logic        VE [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 0};
  localparam string       VT [NV] = '{"R1", "R1", "R6", "R5", "R5", "R8", "R8",
    "R8", "R5", "R4"};

  logic [1:0]  exp_f [4], got_f [4];
  logic [31:0] exp_b [4], got_b [4];
  logic [5:0]  exp_l [4], got_l [4];
  logic        exp_e [4], got_e [4];

  task automatic check(input string tag, input bit ok, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic drive(input logic [63:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      bit hs;
      in_valid = 1'b1;
      in_bit   = s[n-1-i];
      in_last  = (i == n - 1);
      do begin
        #1;
        hs = in_ready;
        @(posedge clk);
        @(negedge clk);
      end while (!hs);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic monitor(input int nrec, input bit stall, input string tag);
    int got = 0, hold = 0;
    logic [1:0] sf; logic [31:0] sb; logic [5:0] sl; logic se;
    while (got < nrec) begin
      @(negedge clk);
      out_ready = 1'b1;
      if (stall && out_valid && hold < 4) begin
        out_ready = 1'b0;
        #1;
        if (hold == 0) begin
          sf = out_first; sb = out_bits; sl = out_len; se = out_err;
        end else begin
          // R9: record held while stalled
          check(tag, {out_first, out_bits, out_len, out_err} == {sf, sb, sl, se},
                $sformatf("R9 record changed under stall got %h/%h/%0d/%0d exp %h/%h/%0d/%0d",
                          out_first, out_bits, out_len, out_err, sf, sb, sl, se));
        end
        // R9: input not accepted while record waits
        check(tag, in_ready == 1'b0, $sformatf("R9 in_ready got %0b exp 0", in_ready));
        hold++;
      end else if (out_valid) begin
        got_f[got] = out_first; got_b[got] = out_bits;
        got_l[got] = out_len;   got_e[got] = out_err;
        got++;
        hold = 0;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic run_case(input string tag, input logic [63:0] s, input int n,
                          input int nrec, input bit stall);
    fork
      drive(s, n);
      monitor(nrec, stall, tag);
    join
    for (int k = 0; k < nrec; k++) begin
      check(tag, got_f[k] == exp_f[k] && got_b[k] == exp_b[k] &&
                 got_l[k] == exp_l[k] && got_e[k] == exp_e[k],
            $sformatf("record %0d got first=%0d bits=%h len=%0d err=%0d exp first=%0d bits=%h len=%0d err=%0d",
                      k, got_f[k], got_b[k], got_l[k], got_e[k],
                      exp_f[k], exp_b[k], exp_l[k], exp_e[k]));
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_exp(input int k, input logic [1:0] f, input logic [31:0] b,
                         input logic [5:0] l, input logic e);
    exp_f[k] = f; exp_b[k] = b; exp_l[k] = l; exp_e[k] = e;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", out_valid == 1'b0, $sformatf("out_valid got %0b exp 0", out_valid));
    check("R10", in_ready == 1'b1, $sformatf("in_ready got %0b exp 1", in_ready));

    // Table walk: single-codeword streams
    for (int v = 0; v < NV; v++) begin
      set_exp(0, VF[v], VB[v], VL[v], VE[v]);
      run_case(VT[v], VS[v], VN[v], 1, 1'b0);
    end

    // R3, R6, R2: three codewords split by terminating zeros
    set_exp(0, 2'd1, 32'h3, 6'd3, 1'b0);
    set_exp(1, 2'd0, 32'h3, 6'd2, 1'b0);
    set_exp(2, 2'd1, 32'h7, 6'd4, 1'b0);
    run_case("R3", {49'd0, 15'b010110011010111}, 15, 3, 1'b0);

    // R9: same stream with the consumer stalling each record
    run_case("R9", {49'd0, 15'b010110011010111}, 15, 3, 1'b1);

    // R3, R8: terminator zero is also the last bit
    set_exp(0, 2'd2, 32'h3, 6'd3, 1'b0);
    set_exp(1, 2'd0, 32'h0, 6'd0, 1'b1);
    run_case("R3", 64'b100110, 6, 2, 1'b0);

    // R7: overflow, then the unconsumed bit heads the next codeword
    set_exp(0, 2'd0, 32'hAAAAAAAA, 6'd32, 1'b1);
    set_exp(1, 2'd1, 32'h3, 6'd2, 1'b0);
    run_case("R7", {26'd0, 2'b00, 32'hAAAAAAAA, 4'b0111}, 38, 2, 1'b0);

    // R7, R2: exactly full tail ending on a delimiter
    set_exp(0, 2'd0, 32'hAAAAAAAB, 6'd32, 1'b0);
    run_case("R7", {30'd0, 2'b00, 30'h2AAAAAAA, 2'b11}, 34, 1, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule